// File: doc/BRIEF.md
# Shifting Bit-Array Triplet Finder

This block looks for three-layer coincidences (triplets) among hits on three concentric cylindrical detector layers. Only one bitwise coincidence network serves every angle. During loading, each layer-1 and layer-2 hit angle sets one bit in a 128-bin angle-indexed bit array for that layer. The block takes one hit per layer per clock.

During the search phase, one layer-3 hit is presented per clock. From that hit's angle the block derives a scaled shift amount for each inner layer, and it rotates both stored arrays by these amounts. Each bin then holds an angle relative to the layer-3 hit, centred on bin 64. A fixed map of (layer-1 bin, layer-2 bin) pairs is tested on the rotated arrays. The valid-track map does not change under rotation, so one copy of the coincidence test covers every layer-3 angle. For each layer-3 hit the block returns a registered result: a found flag, the index of the lowest matching map pair, and the layer-3 angle. A clear strobe empties both arrays before the next event is loaded.

Top module: `ring_triplet_finder`

## Requirements
- R1: A cycle with `l1_vld` high sets the bit at `l1_ang` in the layer-1 array at the clock edge, and `l2_vld`/`l2_ang` do the same for the layer-2 array. The two layers load independently, each at one hit per cycle.
- R2: `clr` empties both arrays at the clock edge. A hit presented in the same cycle as `clr` is dropped.
- R3: For a layer-3 angle a, the layer-1 shift is floor(a*SCALE1/64) mod 128 and the layer-2 shift is floor(a*SCALE2/64) mod 128. The defaults are SCALE1=32 and SCALE2=48, with FRAC=6.
- R4: A stored layer-k angle p has relative bin (p - shift_k + 64) mod 128. Pair i matches when relative bin MAP1[i] is set in layer 1 and relative bin MAP2[i] is set in layer 2. `trip_found` is 1 when any pair matches. The default pairs are i=0:(64,64), i=1:(60,62), i=2:(68,66), i=3:(56,60).
- R5: When several pairs match, `trip_idx` carries the lowest matching pair index as a binary number.
- R6: A cycle with `l3_vld` high gives `trip_vld` high in the next cycle, with `trip_ang` equal to that layer-3 angle. The search sees the arrays as they stood before any hits written in the same cycle, and a search never changes the arrays.
- R7: After reset, both arrays are empty and `trip_vld` and `trip_found` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Empty both bit arrays |
| l1_vld | input | 1 | Layer-1 hit strobe |
| l1_ang | input | 7 | Layer-1 hit angle bin |
| l2_vld | input | 1 | Layer-2 hit strobe |
| l2_ang | input | 7 | Layer-2 hit angle bin |
| l3_vld | input | 1 | Layer-3 hit strobe, starts one search |
| l3_ang | input | 7 | Layer-3 hit angle bin |
| trip_vld | output | 1 | Search result valid |
| trip_found | output | 1 | At least one map pair matched |
| trip_idx | output | 2 | Lowest matching pair index |
| trip_ang | output | 7 | Layer-3 angle of this result |

## Verification
Hits are placed at the angles that a chosen pair and layer-3 angle require, and at angles that would only match if the scaling were left out. This separates a correct shift from an unscaled or mis-signed one. Several pairs are made to match at once to expose the priority order. Layer-3 angles near the top of the circle force the relative bins to wrap. Other cases cover one-layer-only hits, clear with a same-cycle hit, and a hit written in the same cycle as a search. These show that a match needs both layers, that clear wins, and that a search sees the array state from before the edge.

// File: rtl/tf_pkg.sv
package tf_pkg;
  // Shift amount for one inner layer: floor(ang*scale / 2^frac) modulo 2^ang_w.
  function automatic int tf_shift(input int ang, input int scale, input int frac, input int ang_w);
    return ((ang * scale) >> frac) & ((1 << ang_w) - 1);
  endfunction
endpackage

// File: rtl/tf_rst_sync.sv
module tf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/tf_bit_array.sv
module tf_bit_array #(
  parameter int ANG_W = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    set_vld,
  input  logic [ANG_W-1:0]        set_ang,
  output logic [(1<<ANG_W)-1:0]   bits
);
  localparam int NBINS = 1 << ANG_W;

  logic [NBINS-1:0] bits_nxt;
  logic             bits_en;

  always_comb begin
    bits_nxt = bits;
    if (clr)          bits_nxt = '0;
    else if (set_vld) bits_nxt[set_ang] = 1'b1;
  end

  assign bits_en = clr | set_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bits <= '0;
    else if (bits_en) bits <= bits_nxt;
  end
endmodule

// File: rtl/tf_rotator.sv
module tf_rotator #(
  parameter int ANG_W = 7
) (
  input  logic [(1<<ANG_W)-1:0] din,
  input  logic [ANG_W-1:0]      off,
  output logic [(1<<ANG_W)-1:0] dout
);
  localparam int NBINS = 1 << ANG_W;

  // dout[j] = din[(j + off) mod NBINS], built as log2 stages
  logic [NBINS-1:0] stg [0:ANG_W];
  assign stg[0] = din;

  for (genvar s = 0; s < ANG_W; s++) begin : g_stage
    localparam int K = 1 << s;
    assign stg[s+1] = off[s] ? {stg[s][K-1:0], stg[s][NBINS-1:K]} : stg[s];
  end

  assign dout = stg[ANG_W];
endmodule

// File: rtl/tf_match.sv
module tf_match #(
  parameter int                       ANG_W  = 7,
  parameter int                       NPAIRS = 4,
  parameter logic [NPAIRS*ANG_W-1:0]  MAP1   = '0,
  parameter logic [NPAIRS*ANG_W-1:0]  MAP2   = '0,
  localparam int                      IDX_W  = (NPAIRS > 1) ? $clog2(NPAIRS) : 1
) (
  input  logic [(1<<ANG_W)-1:0] rel1,
  input  logic [(1<<ANG_W)-1:0] rel2,
  output logic                  found,
  output logic [IDX_W-1:0]      idx
);
  logic [NPAIRS-1:0] hit;

  for (genvar p = 0; p < NPAIRS; p++) begin : g_pair
    localparam logic [ANG_W-1:0] B1 = MAP1[p*ANG_W +: ANG_W];
    localparam logic [ANG_W-1:0] B2 = MAP2[p*ANG_W +: ANG_W];
    assign hit[p] = rel1[B1] & rel2[B2];
  end

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int p = NPAIRS - 1; p >= 0; p--) begin
      if (hit[p]) begin
        found = 1'b1;
        idx   = IDX_W'(p);
      end
    end
  end
endmodule

// File: rtl/ring_triplet_finder.sv
module ring_triplet_finder
  import tf_pkg::*;
#(
  parameter int                       ANG_W  = 7,
  parameter int                       NPAIRS = 4,
  parameter int                       FRAC   = 6,
  parameter int                       SCALE1 = 32,
  parameter int                       SCALE2 = 48,
  parameter logic [NPAIRS*ANG_W-1:0]  MAP1   = {7'd56, 7'd68, 7'd60, 7'd64},
  parameter logic [NPAIRS*ANG_W-1:0]  MAP2   = {7'd60, 7'd66, 7'd62, 7'd64},
  localparam int                      IDX_W  = (NPAIRS > 1) ? $clog2(NPAIRS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              l1_vld,
  input  logic [ANG_W-1:0]  l1_ang,
  input  logic              l2_vld,
  input  logic [ANG_W-1:0]  l2_ang,
  input  logic              l3_vld,
  input  logic [ANG_W-1:0]  l3_ang,
  output logic              trip_vld,
  output logic              trip_found,
  output logic [IDX_W-1:0]  trip_idx,
  output logic [ANG_W-1:0]  trip_ang
);
  localparam int NBINS = 1 << ANG_W;
  localparam logic [ANG_W-1:0] CENTER = ANG_W'(NBINS / 2);

  logic             rst_ns;
  logic [NBINS-1:0] bits1, bits2;
  logic [NBINS-1:0] rel1, rel2;
  logic [ANG_W-1:0] shift1, shift2, off1, off2;
  logic             m_found;
  logic [IDX_W-1:0] m_idx;

  logic             found_nxt;
  logic [IDX_W-1:0] idx_nxt;
  logic [ANG_W-1:0] ang_nxt;
  logic             res_en;

  tf_rst_sync i_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  tf_bit_array #(.ANG_W(ANG_W)) i_arr1 (
    .clk(clk), .rst_n(rst_ns), .clr(clr),
    .set_vld(l1_vld), .set_ang(l1_ang), .bits(bits1));

  tf_bit_array #(.ANG_W(ANG_W)) i_arr2 (
    .clk(clk), .rst_n(rst_ns), .clr(clr),
    .set_vld(l2_vld), .set_ang(l2_ang), .bits(bits2));

  // Scaled shift per inner layer, then offset so relative bin = p - shift + center
  always_comb begin
    shift1 = ANG_W'(tf_shift(int'(l3_ang), SCALE1, FRAC, ANG_W));
    shift2 = ANG_W'(tf_shift(int'(l3_ang), SCALE2, FRAC, ANG_W));
    off1   = shift1 - CENTER;
    off2   = shift2 - CENTER;
  end

  tf_rotator #(.ANG_W(ANG_W)) i_rot1 (.din(bits1), .off(off1), .dout(rel1));
  tf_rotator #(.ANG_W(ANG_W)) i_rot2 (.din(bits2), .off(off2), .dout(rel2));

  tf_match #(.ANG_W(ANG_W), .NPAIRS(NPAIRS), .MAP1(MAP1), .MAP2(MAP2)) i_match (
    .rel1(rel1), .rel2(rel2), .found(m_found), .idx(m_idx));

  always_comb begin
    found_nxt = l3_vld & m_found;
    idx_nxt   = m_idx;
    ang_nxt   = l3_ang;
    res_en    = l3_vld;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      trip_vld   <= 1'b0;
      trip_found <= 1'b0;
    end else begin
      trip_vld   <= l3_vld;
      trip_found <= found_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      trip_idx <= '0;
      trip_ang <= '0;
    end else if (res_en) begin
      trip_idx <= idx_nxt;
      trip_ang <= ang_nxt;
    end
  end
endmodule

// File: rtl/tf_checker.sv
module tf_checker #(
  parameter int ANG_W = 7
) (
  input logic                  clk,
  input logic                  rst_ns,
  input logic                  clr,
  input logic                  l1_vld,
  input logic [ANG_W-1:0]      l1_ang,
  input logic                  l2_vld,
  input logic [ANG_W-1:0]      l2_ang,
  input logic                  l3_vld,
  input logic [ANG_W-1:0]      l3_ang,
  input logic [(1<<ANG_W)-1:0] bits1,
  input logic [(1<<ANG_W)-1:0] bits2,
  input logic                  trip_vld,
  input logic                  trip_found,
  input logic [ANG_W-1:0]      trip_ang
);
  a_r1_l1_sets: assert property (@(posedge clk) disable iff (!rst_ns)
    (l1_vld && !clr) |=> bits1[$past(l1_ang)]);

  a_r1_l2_sets: assert property (@(posedge clk) disable iff (!rst_ns)
    (l2_vld && !clr) |=> bits2[$past(l2_ang)]);

  a_r2_clear_empties: assert property (@(posedge clk) disable iff (!rst_ns)
    clr |=> (bits1 == '0 && bits2 == '0));

  a_r4_found_only_valid: assert property (@(posedge clk) disable iff (!rst_ns)
    trip_found |-> trip_vld);

  a_r6_vld_follows: assert property (@(posedge clk) disable iff (!rst_ns)
    l3_vld |=> trip_vld);

  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_ns)
    !l3_vld |=> !trip_vld);

  a_r6_angle_echo: assert property (@(posedge clk) disable iff (!rst_ns)
    l3_vld |=> (trip_ang == $past(l3_ang)));

  a_r6_search_keeps_arrays: assert property (@(posedge clk) disable iff (!rst_ns)
    (!l1_vld && !l2_vld && !clr) |=> ($stable(bits1) && $stable(bits2)));
endmodule

bind ring_triplet_finder tf_checker #(.ANG_W(ANG_W)) i_tf_checker (
  .clk(clk), .rst_ns(rst_ns), .clr(clr),
  .l1_vld(l1_vld), .l1_ang(l1_ang), .l2_vld(l2_vld), .l2_ang(l2_ang),
  .l3_vld(l3_vld), .l3_ang(l3_ang), .bits1(bits1), .bits2(bits2),
  .trip_vld(trip_vld), .trip_found(trip_found), .trip_ang(trip_ang));

// File: tb/test_ring_triplet_finder.sv
module test_ring_triplet_finder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       l1_vld = 1'b0, l2_vld = 1'b0, l3_vld = 1'b0;
  logic [6:0] l1_ang = '0, l2_ang = '0, l3_ang = '0;
  logic       trip_vld, trip_found;
  logic [1:0] trip_idx;
  logic [6:0] trip_ang;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Requirement constants: pair map, scales, centre (R3, R4)
  int map1 [4] = '{64, 60, 68, 56};
  int map2 [4] = '{64, 62, 66, 60};
  localparam int SC1 = 32, SC2 = 48;

  bit [127:0] m1 = '0, m2 = '0;

  int    q_idx [$];
  int    q_ang [$];
  string q_req [$];

  ring_triplet_finder i_ring_triplet_finder (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .l1_vld(l1_vld), .l1_ang(l1_ang), .l2_vld(l2_vld), .l2_ang(l2_ang),
    .l3_vld(l3_vld), .l3_ang(l3_ang),
    .trip_vld(trip_vld), .trip_found(trip_found), .trip_idx(trip_idx), .trip_ang(trip_ang));

  always #2.5 clk = ~clk;

  function automatic int shf(int a, int sc);
    return ((a * sc) >> 6) & 127;
  endfunction

  // Stored angle that lands pair p of layer k at layer-3 angle a
  function automatic int pos_for(int layer, int p, int a);
    if (layer == 1) return (map1[p] + shf(a, SC1) - 64) & 127;
    else            return (map2[p] + shf(a, SC2) - 64) & 127;
  endfunction

  // Expected lowest matching pair, -1 for none
  function automatic int expect_idx(int a);
    for (int p = 0; p < 4; p++) begin
      if (m1[(map1[p] + shf(a, SC1) - 64) & 127] && m2[(map2[p] + shf(a, SC2) - 64) & 127])
        return p;
    end
    return -1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put1(int a);
    @(negedge clk); l1_vld = 1'b1; l1_ang = 7'(a);
    @(posedge clk); #1; l1_vld = 1'b0; m1[a] = 1'b1;
  endtask

  task automatic put2(int a);
    @(negedge clk); l2_vld = 1'b1; l2_ang = 7'(a);
    @(posedge clk); #1; l2_vld = 1'b0; m2[a] = 1'b1;
  endtask

  task automatic wipe();
    @(negedge clk); clr = 1'b1;
    @(posedge clk); #1; clr = 1'b0; m1 = '0; m2 = '0;
  endtask

  // Driver: push expected result, then present the layer-3 hit
  task automatic query(int a, string req);
    @(negedge clk);
    q_idx.push_back(expect_idx(a)); q_ang.push_back(a); q_req.push_back(req);
    l3_vld = 1'b1; l3_ang = 7'(a);
    @(posedge clk); #1; l3_vld = 1'b0;
  endtask

  task automatic query_expect(int a, int exp, string req);
    chk({req, " model"}, expect_idx(a), exp);
    query(a, req);
  endtask

  // Monitor: pop and compare each result
  always @(negedge clk) begin
    if (rst_n && trip_vld) begin
      if (q_idx.size() == 0) begin
        chk("R6 unexpected result", 1, 0);
      end else begin
        automatic int    ei = q_idx.pop_front();
        automatic int    ea = q_ang.pop_front();
        automatic string er = q_req.pop_front();
        chk({er, " found"}, int'(trip_found), (ei >= 0) ? 1 : 0);
        if (ei >= 0) chk({er, " idx"}, int'(trip_idx), ei);
        chk("R6 angle", int'(trip_ang), ea);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R7 trip_vld after reset", int'(trip_vld), 0);
    chk("R7 trip_found after reset", int'(trip_found), 0);
    query_expect(10, -1, "R7 empty arrays");

    // Basic pair 0 at angle 0
    put1(pos_for(1, 0, 0)); put2(pos_for(2, 0, 0));
    query_expect(0, 0, "R4 pair0 at 0");
    query(5, "R4 other angle");

    // Unscaled placement must not match once scaling applies (R3)
    wipe();
    query_expect(0, -1, "R2 after clear");
    put1(77); put2(77);
    query(77, "R3 unscaled placement");
    chk("R3 unscaled gives no match", expect_idx(77), -1);

    // Two pairs match: lowest index wins
    wipe();
    put1(pos_for(1, 3, 100)); put2(pos_for(2, 3, 100));
    put1(pos_for(1, 1, 100)); put2(pos_for(2, 1, 100));
    query_expect(100, 1, "R5 lowest of pairs 1 and 3");
    query_expect(100, 1, "R6 repeated search unchanged");

    // Wrapping angles, one layer alone
    wipe();
    put1(pos_for(1, 0, 120));
    query_expect(120, -1, "R4 layer1 only");
    put2(pos_for(2, 0, 120));
    query_expect(120, 0, "R3 wrap at 120");

    // Clear wins over a same-cycle hit
    wipe();
    @(negedge clk); clr = 1'b1; l1_vld = 1'b1; l1_ang = 7'(pos_for(1, 0, 7));
    @(posedge clk); #1; clr = 1'b0; l1_vld = 1'b0; m1 = '0; m2 = '0;
    put2(pos_for(2, 0, 7));
    query_expect(7, -1, "R2 hit dropped under clear");

    // Hit written in the same cycle as a search is not seen by it
    wipe();
    put2(pos_for(2, 2, 50));
    @(negedge clk);
    q_idx.push_back(expect_idx(50)); q_ang.push_back(50); q_req.push_back("R6 same-cycle write");
    l1_vld = 1'b1; l1_ang = 7'(pos_for(1, 2, 50)); l3_vld = 1'b1; l3_ang = 7'd50;
    @(posedge clk); #1; l1_vld = 1'b0; l3_vld = 1'b0; m1[pos_for(1, 2, 50)] = 1'b1;
    query_expect(50, 2, "R1 layer1 bit stored");

    repeat (4) @(negedge clk);
    chk("R6 all results seen", q_idx.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule